// File: doc/BRIEF.md
# Vectored Interrupt Priority Arbiter

This block keeps track of which of 256 interrupt vectors are waiting, which are being serviced and which were raised as level-triggered. Each vector has one bit in each of three 256-bit registers. A vector's upper four bits are its priority class. A larger vector number wins over a smaller one. Requests arrive one vector per cycle, each with a trigger mode. The block compares the best waiting vector against a processor priority and raises `irq` while that vector may be delivered. The processor priority is built from the task priority input and the most urgent vector in service.

The core takes an interrupt by pulsing `ack`. One cycle later the block returns either the vector to service or the programmed spurious vector. When it returns a real vector, that vector moves from waiting to in-service. The core finishes a handler by pulsing `eoi`. This retires the most urgent in-service vector. If that vector was level-triggered and directed end-of-interrupt is off, the block pulses `eoi_bcast` one cycle later with the vector number, so the interrupt source can be re-armed. A 9-bit spurious register holds the spurious vector and a software enable.

The control is a three-state machine:
- `ST_IDLE` accepts `ack` and `eoi`.
- `ST_GRANT` presents the acknowledge result.
- `ST_RETIRE` presents an end-of-interrupt broadcast.

There are four transitions:
- IDLE→GRANT on an acknowledge.
- IDLE→RETIRE on an end-of-interrupt that must be broadcast.
- GRANT→IDLE and RETIRE→IDLE after one cycle each.

An end-of-interrupt that needs no broadcast keeps the machine in IDLE.

Top module: `ivec_arbiter`

## Requirements
- R1: After reset the waiting, in-service and trigger registers are empty. The spurious register holds vector 0xFF with the enable clear (value 0x0FF). `irq`, `ack_valid` and `eoi_bcast` are low.
- R2: A request with `set_level`=1 marks the vector waiting and sets its trigger bit. With `set_level`=0 it marks the vector waiting and clears its trigger bit. The last request for a vector decides whether its later end-of-interrupt is broadcast.
- R3: The best waiting vector is the highest-numbered waiting vector.
- R4: The processor priority equals `tpr` when `tpr[7:4]` is at least the class of the highest in-service vector. Otherwise it equals that vector with bits 3:0 cleared. With nothing in service, the processor priority equals `tpr`.
- R5: `irq` is high exactly when all of these hold:
  - the enable bit (bit 8) of the spurious register is set;
  - some vector is waiting;
  - the processor priority is zero, or the class of the best waiting vector is strictly greater than the class of the processor priority.
- R6: An `ack` taken in IDLE while `irq` is high makes `ack_valid` high in the next cycle, with `ack_vec` equal to the best waiting vector. That vector's waiting bit clears and its in-service bit sets. A request for the same vector in the same cycle leaves it waiting.
- R7: An `ack` taken in IDLE while `irq` is low gives `ack_valid` in the next cycle with `ack_vec` equal to bits 7:0 of the spurious register. The registers are left unchanged.
- R8: An `eoi` taken in IDLE clears the highest in-service bit. If that vector's trigger bit is set and `eoi_directed` is low, `eoi_bcast` is high in the next cycle for one cycle, with `eoi_vec` equal to the vector.
- R9: An `eoi` with no in-service bit set changes nothing and gives no broadcast.
- R10: `cfg_we` loads all 9 bits of `cfg_wdata` into the spurious register: bits 7:0 are the vector and bit 8 is the enable.
- R11: When `ack` and `eoi` arrive in the same IDLE cycle, only `eoi` is taken. `ack` and `eoi` arriving in GRANT or RETIRE are ignored. Both of those states return to IDLE after one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_valid | input | 1 | Raise the vector on `set_vec` this cycle |
| set_vec | input | 8 | Vector being raised |
| set_level | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| tpr | input | 8 | Task priority |
| cfg_we | input | 1 | Write the spurious register |
| cfg_wdata | input | 9 | Bit 8 enable, bits 7:0 spurious vector |
| eoi_directed | input | 1 | Suppress end-of-interrupt broadcast |
| ack | input | 1 | Acknowledge strobe from the core |
| eoi | input | 1 | End-of-interrupt strobe from the core |
| irq | output | 1 | A deliverable vector is waiting |
| ack_valid | output | 1 | Acknowledge result valid |
| ack_vec | output | 8 | Vector to service, or the spurious vector |
| eoi_bcast | output | 1 | Broadcast strobe for a retired level-triggered vector |
| eoi_vec | output | 8 | Vector carried by the broadcast |

## Verification
The assertions assume that `ack` and `eoi` are pulses that the core may raise in any cycle, including the GRANT and RETIRE cycles where the block ignores them. They also assume that `tpr`, `eoi_directed` and the request inputs settle before the active edge. The stimulus keeps to this by driving every input on the falling edge. It mixes random strobes that can collide with each other and with requests for the vector being granted. Task-priority changes are rare so that blocking by class is held long enough to be observed.

// File: rtl/ivec_pkg.sv
package ivec_pkg;
    localparam int CLASS_W = 4;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_GRANT  = 2'd1,
        ST_RETIRE = 2'd2
    } arb_state_e;
endpackage

// File: rtl/ivec_scan.sv
module ivec_scan #(
    parameter int N      = 256,
    parameter int VW     = 8,
    parameter int WORD_W = 32
) (
    input  logic [N-1:0]  bits,
    output logic          found,
    output logic [VW-1:0] idx
);
    localparam int NW = N / WORD_W;
    localparam int WW = $clog2(WORD_W);

    logic [NW-1:0]         word_any;
    logic [NW-1:0][WW-1:0] word_idx;

    for (genvar w = 0; w < NW; w++) begin : g_word
        logic [WW-1:0] pos;
        always_comb begin
            pos = '0;
            for (int b = 0; b < WORD_W; b++) begin
                if (bits[w*WORD_W + b]) pos = WW'(b);
            end
        end
        assign word_any[w] = |bits[w*WORD_W +: WORD_W];
        assign word_idx[w] = pos;
    end

    // Higher words overwrite lower ones, so the topmost non-empty word wins.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int w = 0; w < NW; w++) begin
            if (word_any[w]) begin
                found = 1'b1;
                idx   = VW'(w*WORD_W + int'(word_idx[w]));
            end
        end
    end

    // R3: a reported vector is always one of the set bits
    always_comb begin
        a_r3_found_is_set: assert (!found || bits[idx]);
    end
endmodule

// File: rtl/ivec_prio_gate.sv
module ivec_prio_gate
    import ivec_pkg::*;
#(
    parameter int VW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sw_en,
    input  logic          pend_found,
    input  logic [VW-1:0] pend_idx,
    input  logic          isr_found,
    input  logic [VW-1:0] isr_idx,
    input  logic [VW-1:0] tpr,
    output logic [VW-1:0] ppr,
    output logic          deliver
);
    logic [VW-1:0]      isr_eff;
    logic [CLASS_W-1:0] isr_cls;
    logic [CLASS_W-1:0] tpr_cls;
    logic [CLASS_W-1:0] pend_cls;
    logic [CLASS_W-1:0] ppr_cls;

    assign isr_eff  = isr_found ? isr_idx : '0;
    assign isr_cls  = isr_eff[VW-1 -: CLASS_W];
    assign tpr_cls  = tpr[VW-1 -: CLASS_W];
    assign pend_cls = pend_idx[VW-1 -: CLASS_W];

    always_comb begin
        if (tpr_cls >= isr_cls) ppr = tpr;
        else                    ppr = {isr_cls, {(VW-CLASS_W){1'b0}}};
    end

    assign ppr_cls = ppr[VW-1 -: CLASS_W];
    assign deliver = sw_en && pend_found &&
                     ((ppr == '0) || (pend_cls > ppr_cls));

    // R4: a deliverable vector outranks any nonzero class in service
    a_r4_outranks_service: assert property (@(posedge clk) disable iff (!rst_n)
        (deliver && isr_found && isr_cls != '0) |-> (pend_cls > isr_cls));
endmodule

// File: rtl/ivec_arbiter.sv
module ivec_arbiter
    import ivec_pkg::*;
#(
    parameter int NVEC = 256,
    parameter int VW   = $clog2(NVEC)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_valid,
    input  logic [VW-1:0] set_vec,
    input  logic          set_level,
    input  logic [VW-1:0] tpr,
    input  logic          cfg_we,
    input  logic [VW:0]   cfg_wdata,
    input  logic          eoi_directed,
    input  logic          ack,
    input  logic          eoi,
    output logic          irq,
    output logic          ack_valid,
    output logic [VW-1:0] ack_vec,
    output logic          eoi_bcast,
    output logic [VW-1:0] eoi_vec
);
    localparam logic [VW:0] SPV_RESET = {1'b0, {VW{1'b1}}};

    logic [NVEC-1:0] pend_q, isr_q, trig_q;
    logic [VW:0]     spv_q;
    logic [VW-1:0]   ack_vec_q, eoi_vec_q;
    arb_state_e      state_q, state_d;

    logic          pend_found, isr_found, deliver;
    logic [VW-1:0] pend_idx, isr_idx, ppr;
    logic          take_ack, take_eoi, do_bcast;

    ivec_scan #(.N(NVEC), .VW(VW)) u_pend_scan (
        .bits(pend_q), .found(pend_found), .idx(pend_idx));

    ivec_scan #(.N(NVEC), .VW(VW)) u_isr_scan (
        .bits(isr_q), .found(isr_found), .idx(isr_idx));

    ivec_prio_gate #(.VW(VW)) u_gate (
        .clk(clk), .rst_n(rst_n), .sw_en(spv_q[VW]),
        .pend_found(pend_found), .pend_idx(pend_idx),
        .isr_found(isr_found), .isr_idx(isr_idx),
        .tpr(tpr), .ppr(ppr), .deliver(deliver));

    assign irq      = deliver;
    assign take_eoi = (state_q == ST_IDLE) && eoi;
    assign take_ack = (state_q == ST_IDLE) && ack && !eoi;
    assign do_bcast = take_eoi && isr_found && trig_q[isr_idx] && !eoi_directed;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (do_bcast)      state_d = ST_RETIRE;
                else if (take_ack) state_d = ST_GRANT;
                else               state_d = ST_IDLE;
            end
            ST_GRANT:  state_d = ST_IDLE;
            ST_RETIRE: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // vector registers; a request is applied after an acknowledge clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q    <= '0;
            isr_q     <= '0;
            trig_q    <= '0;
            spv_q     <= SPV_RESET;
            ack_vec_q <= '0;
            eoi_vec_q <= '0;
        end else begin
            if (cfg_we) spv_q <= cfg_wdata;
            if (take_eoi && isr_found) begin
                isr_q[isr_idx] <= 1'b0;
                eoi_vec_q      <= isr_idx;
            end
            if (take_ack) begin
                if (deliver) begin
                    pend_q[pend_idx] <= 1'b0;
                    isr_q[pend_idx]  <= 1'b1;
                    ack_vec_q        <= pend_idx;
                end else begin
                    ack_vec_q <= spv_q[VW-1:0];
                end
            end
            if (set_valid) begin
                pend_q[set_vec] <= 1'b1;
                trig_q[set_vec] <= set_level;
            end
        end
    end

    // outputs decoded from the state
    always_comb begin
        ack_valid = 1'b0;
        eoi_bcast = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_GRANT:  ack_valid = 1'b1;
            ST_RETIRE: eoi_bcast = 1'b1;
            default:   ;
        endcase
    end
    assign ack_vec = ack_vec_q;
    assign eoi_vec = eoi_vec_q;

    // R5: an interrupt is only requested when enabled and something waits
    a_r5_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (spv_q[VW] && (|pend_q)));

    // R6: a granted vector is in service when it is presented
    a_r6_grant_in_service: assert property (@(posedge clk) disable iff (!rst_n)
        (take_ack && irq) |=> (ack_valid && isr_q[ack_vec_q]));

    // R8: a broadcast vector has left service and was not directed
    a_r8_bcast_retired: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_bcast |-> (!isr_q[eoi_vec] && !$past(eoi_directed)));

    // R9: an end-of-interrupt with nothing in service leaves service state alone
    a_r9_empty_eoi: assert property (@(posedge clk) disable iff (!rst_n)
        (take_eoi && !(|isr_q)) |=> ($stable(isr_q) && !eoi_bcast));

    // R11: result states last exactly one cycle
    a_r11_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> (state_q == ST_IDLE));
endmodule

// File: tb/tb_ivec_arbiter.sv
`timescale 1ns/1ps
module tb_ivec_arbiter;
    localparam int NV = 256;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       set_valid = 0, set_level = 0, cfg_we = 0;
    logic       eoi_directed = 0, ack = 0, eoi = 0;
    logic [7:0] set_vec = 0, tpr = 0;
    logic [8:0] cfg_wdata = 0;
    logic       irq, ack_valid, eoi_bcast;
    logic [7:0] ack_vec, eoi_vec;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    ivec_arbiter dut (
        .clk(clk), .rst_n(rst_n), .set_valid(set_valid), .set_vec(set_vec),
        .set_level(set_level), .tpr(tpr), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .eoi_directed(eoi_directed), .ack(ack), .eoi(eoi), .irq(irq),
        .ack_valid(ack_valid), .ack_vec(ack_vec), .eoi_bcast(eoi_bcast),
        .eoi_vec(eoi_vec));

    // reference model
    logic [NV-1:0] m_pend = '0, m_isr = '0, m_trig = '0;
    logic [8:0]    m_spv = 9'h0FF;
    int            m_state = 0;
    logic [7:0]    m_ackv = 0, m_eoiv = 0;
    bit            m_spur = 0;

    function automatic int top_bit(logic [NV-1:0] v);
        for (int i = NV-1; i >= 0; i--) if (v[i]) return i;
        return -1;
    endfunction

    function automatic bit model_irq();
        int pv = top_bit(m_pend);
        int iv = top_bit(m_isr);
        int pr;
        if (!m_spv[8] || pv < 0) return 0;
        if (iv < 0) iv = 0;
        if ((int'(tpr) >> 4) >= (iv >> 4)) pr = int'(tpr);
        else pr = iv & 'hF0;
        if (pr != 0 && (pv >> 4) <= (pr >> 4)) return 0;
        return 1;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        logic [NV-1:0] np = m_pend, ni = m_isr, nt = m_trig;
        logic [8:0] ns = m_spv;
        int st = 0;
        logic [7:0] av = m_ackv, ev = m_eoiv;
        bit sp = m_spur;
        if (cfg_we) ns = cfg_wdata;
        if (m_state == 0) begin
            if (eoi) begin
                int t = top_bit(m_isr);
                if (t >= 0) begin
                    ni[t] = 1'b0;
                    ev = 8'(t);
                    if (m_trig[t] && !eoi_directed) st = 2;
                end
            end else if (ack) begin
                st = 1;
                if (model_irq()) begin
                    int v = top_bit(m_pend);
                    np[v] = 1'b0; ni[v] = 1'b1; av = 8'(v); sp = 0;
                end else begin
                    av = m_spv[7:0]; sp = 1;
                end
            end
        end
        if (set_valid) begin
            np[set_vec] = 1'b1;
            nt[set_vec] = set_level;
        end
        @(posedge clk);
        m_pend = np; m_isr = ni; m_trig = nt; m_spv = ns;
        m_state = st; m_ackv = av; m_eoiv = ev; m_spur = sp;
        @(negedge clk);
        set_valid = 0; cfg_we = 0; ack = 0; eoi = 0;
        chk(irq === model_irq(), "R5 irq", int'(irq), int'(model_irq()));
        chk(ack_valid === (m_state == 1), "R6 ack_valid", int'(ack_valid), int'(m_state == 1));
        if (m_state == 1)
            chk(ack_vec === m_ackv, m_spur ? "R7 ack_vec" : "R6 ack_vec", int'(ack_vec), int'(m_ackv));
        chk(eoi_bcast === (m_state == 2), "R8 eoi_bcast", int'(eoi_bcast), int'(m_state == 2));
        if (m_state == 2)
            chk(eoi_vec === m_eoiv, "R8 eoi_vec", int'(eoi_vec), int'(m_eoiv));
    endtask

    task automatic raise(input logic [7:0] v, input logic lvl);
        set_valid = 1; set_vec = v; set_level = lvl;
        tick();
    endtask

    task automatic do_ack(output logic [7:0] v, output logic valid);
        ack = 1;
        tick();
        v = ack_vec; valid = ack_valid;
        tick();
    endtask

    task automatic do_eoi(input logic dir, output logic bc, output logic [7:0] v);
        eoi = 1; eoi_directed = dir;
        tick();
        bc = eoi_bcast; v = eoi_vec;
        eoi_directed = 0;
        tick();
    endtask

    task automatic write_spv(input logic [8:0] d);
        cfg_we = 1; cfg_wdata = d;
        tick();
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic ok, bc;
        void'($urandom(32'h1F2E3D4C));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(irq === 1'b0, "R1 irq", int'(irq), 0);
        chk(ack_valid === 1'b0, "R1 ack_valid", int'(ack_valid), 0);
        chk(eoi_bcast === 1'b0, "R1 eoi_bcast", int'(eoi_bcast), 0);
        do_ack(v, ok);
        chk(ok && v == 8'hFF, "R1 spurious after reset", int'(v), 'hFF);

        raise(8'h45, 0);
        chk(irq === 1'b0, "R5 disabled blocks irq", int'(irq), 0);
        write_spv(9'h13C);
        chk(irq === 1'b1, "R10 enable written", int'(irq), 1);

        raise(8'h92, 1);
        raise(8'h9A, 0);
        do_ack(v, ok);
        chk(v == 8'h9A, "R3 highest vector", int'(v), 'h9A);
        chk(irq === 1'b0, "R4 same class as service blocked", int'(irq), 0);
        do_ack(v, ok);
        chk(v == 8'h3C, "R7 blocked returns spurious", int'(v), 'h3C);
        do_eoi(0, bc, v);
        chk(bc === 1'b0, "R8 edge vector not broadcast", int'(bc), 0);
        chk(irq === 1'b1, "R4 service cleared", int'(irq), 1);

        tpr = 8'hA0;
        #1;
        chk(irq === 1'b0, "R4 task priority blocks", int'(irq), 0);
        do_ack(v, ok);
        chk(v == 8'h3C, "R7 spurious under tpr", int'(v), 'h3C);
        tpr = 8'h00;
        do_ack(v, ok);
        chk(v == 8'h92, "R6 grant", int'(v), 'h92);
        do_eoi(1, bc, v);
        chk(bc === 1'b0, "R8 directed suppresses", int'(bc), 0);
        raise(8'h92, 1);
        do_ack(v, ok);
        do_eoi(0, bc, v);
        chk(bc === 1'b1 && v == 8'h92, "R2 level broadcast", int'(v), 'h92);

        do_eoi(0, bc, v);
        chk(bc === 1'b0, "R9 empty eoi", int'(bc), 0);
        do_ack(v, ok);
        chk(v == 8'h45, "R9 waiting kept", int'(v), 'h45);

        raise(8'h70, 1);
        do_ack(v, ok);
        ack = 1; eoi = 1;
        tick();
        chk(ack_valid === 1'b0, "R11 eoi wins over ack", int'(ack_valid), 0);
        chk(eoi_bcast === 1'b1 && eoi_vec == 8'h70, "R11 eoi taken", int'(eoi_vec), 'h70);
        ack = 1;
        tick();
        chk(ack_valid === 1'b0, "R11 ack ignored when busy", int'(ack_valid), 0);
        tick();

        raise(8'h88, 1);
        raise(8'h88, 0);
        do_ack(v, ok);
        chk(v == 8'h88, "R2 grant", int'(v), 'h88);
        do_eoi(0, bc, v);
        chk(bc === 1'b0, "R2 edge overrides level", int'(bc), 0);
        do_eoi(0, bc, v);

        write_spv(9'h055);
        raise(8'h20, 0);
        chk(irq === 1'b0, "R10 enable cleared", int'(irq), 0);
        do_ack(v, ok);
        chk(v == 8'h55, "R10 new spurious vector", int'(v), 'h55);
        write_spv(9'h13C);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            if ($urandom % 3 == 0) begin
                set_valid = 1; set_vec = 8'($urandom); set_level = 1'($urandom);
            end
            if ($urandom % 20 == 0) tpr = ($urandom % 2 == 0) ? 8'h00 : 8'($urandom);
            if ($urandom % 100 == 0) begin
                cfg_we = 1;
                cfg_wdata = {1'($urandom % 8 != 0), 8'($urandom)};
            end
            eoi_directed = ($urandom % 4 == 0);
            ack = ($urandom % 5 == 0);
            eoi = ($urandom % 5 == 0);
            tick();
        end

        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule